// File: doc/BRIEF.md
# SMI Status Aggregation Register

This block is a 32-bit status register that gathers every cause of a system-management interrupt and drives one active-low, registered SMI request line. Three of its bits latch one-cycle events and keep them until software writes 1 to that bit position. These are the SMBus cause, the periodic tick and an access trap on two fixed I/O ports. Two bits track live request levels from the serial-IRQ decoder and the watchdog/TCO logic. Four bits are live summaries built inside the block from other status registers and their enables: device traps, GPE1, GPE0 and PM1.

Software reads and writes the register through a simple I/O-style port. The port decodes an offset relative to the power-management base, and the register answers at offset 34h. An I/O snoop input shows the block every I/O cycle on the bus, so that it can spot accesses to the power-management microcontroller ports. A 32-bit enable vector qualifies the bits that need their own enable. The summary bits already contain their enables, so they raise SMI unconditionally.

Top module: `smi_cause_reg`

## Requirements
- R1: A synchronous active-low reset clears all latched bits and holds `smi_n` high one cycle after any reset cycle.
- R2: Bits 31:17 and bit 7 always read 0. A read at any offset other than 8'h34 returns 0.
- R3: Bit 16 sets in the cycle after `smb_slave_evt` is high and clears in the cycle after a write of 1 to bit 16 at offset 8'h34.
- R4: Bit 16 also sets after `smb_alert_n` falls from 1 to 0 while `smb_smi_mode` is 1. Holding the alert low sets it only once, and a fall while the mode is 0 does not set it.
- R5: Bit 15 equals `serirq_req` and bit 13 equals `tco_req` in the same cycle, with no memory.
- R6: Bit 14 sets in the cycle after `periodic_tick` and clears on a write of 1 to bit 14.
- R7: Bit 11 sets in the cycle after a snoop access (`io_snoop_valid`) to address 16'h0062 or 16'h0066. Any other address leaves it unchanged, and a write of 1 to bit 11 clears it.
- R8: Bit 12 equals the OR over all traps of `trap_sts & trap_en`.
- R9: Bit 10 equals the OR of `gpe1_sts & gpe1_en & gpe1_route`. Bit 9 equals the OR of `gpe0_sts & gpe0_en`. Bit 8 equals the OR of `pm1_sts & pm1_smi_mask`.
- R10: `smi_n` is 0 in the cycle after any status bit at position p is 1 while either `smi_en[p]` is 1 or p is one of 8, 9, 10, 12.
- R11: When a set event and a write-1 clear hit the same latched bit in one cycle, the bit ends set.
- R12: Several writes change nothing: writes to read-only or reserved bits, zeros written to latched bits, and writes at other offsets.
- R13: `smi_n` stays 0 while a qualified cause persists and returns to 1 in the cycle after the last cause goes away.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | OFS_W (8) | Register offset from the power-management base |
| reg_wr_en | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data (1 clears a latched bit) |
| reg_rdata | output | 32 | Read data at the addressed offset |
| smi_en | input | 32 | Per-bit SMI enables |
| io_snoop_valid | input | 1 | An I/O access is on the bus this cycle |
| io_snoop_addr | input | ADDR_W (16) | Address of the snooped I/O access |
| smb_slave_evt | input | 1 | SMBus slave message pulse |
| smb_alert_n | input | 1 | SMBus alert, active low |
| smb_smi_mode | input | 1 | SMBus host set to report by SMI |
| serirq_req | input | 1 | Serial-IRQ decoder SMI request level |
| periodic_tick | input | 1 | Periodic rate pulse |
| tco_req | input | 1 | TCO logic SMI request level |
| trap_sts | input | NUM_TRAPS | Device trap status bits |
| trap_en | input | NUM_TRAPS | Device trap enables |
| gpe0_sts | input | GPE0_W | GPE0 status bits |
| gpe0_en | input | GPE0_W | GPE0 enables |
| gpe1_sts | input | GPE1_W | GPE1 status bits |
| gpe1_en | input | GPE1_W | GPE1 enables |
| gpe1_route | input | GPE1_W | GPE1 bits routed to SMI |
| pm1_sts | input | PM1_W | PM1 status bits |
| pm1_smi_mask | input | PM1_W | PM1 bits able to cause SMI |
| smi_n | output | 1 | Registered SMI request, active low |

## Verification
The bench builds the block with four device traps, 8-bit GPE0, GPE1 and PM1 vectors, a 16-bit snoop address and the port pair 62h/66h. These small widths make random masks overlap often, so every summary bit toggles many times in a short run. The snoop address is drawn mostly from 60h to 67h, so trap hits and near misses are both frequent. Directed steps cover the cases random stimulus rarely reaches: a held alert, a set and a clear in the same cycle, and stray writes.

// File: rtl/smi_pkg.sv
// Shared bit positions and masks of the SMI status register.
// Assumes a 32-bit register; positions are fixed by software convention.
package smi_pkg;
    localparam int REG_W      = 32;
    localparam int BIT_PM1    = 8;
    localparam int BIT_GPE0   = 9;
    localparam int BIT_GPE1   = 10;
    localparam int BIT_MCPORT = 11;
    localparam int BIT_DEVTRP = 12;
    localparam int BIT_TCO    = 13;
    localparam int BIT_PERIOD = 14;
    localparam int BIT_SERIRQ = 15;
    localparam int BIT_SMBUS  = 16;
    localparam int NUM_LATCH  = 3;

    // Bits that are latched and cleared by writing 1.
    localparam logic [REG_W-1:0] W1C_MASK  = 32'h0001_4800;
    // Summary bits that already include their enables.
    localparam logic [REG_W-1:0] NOEN_MASK = 32'h0000_1700;
    // Reserved bits.
    localparam logic [REG_W-1:0] RSVD_MASK = 32'hFFFE_0080;

    // Bit position of each latched slot, in slot order.
    function automatic int latch_pos(input int slot);
        case (slot)
            0:       return BIT_SMBUS;
            1:       return BIT_PERIOD;
            default: return BIT_MCPORT;
        endcase
    endfunction
endpackage

// File: rtl/smi_w1c_bit.sv
// One latched status bit: set by an event, cleared by writing 1.
// Assumes set_i and clr_i are synchronous to clk; a set beats a clear.
module smi_w1c_bit (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic q
);
    // Hold, set or clear the bit; a set in the same cycle as a clear wins.
    always_ff @(posedge clk) begin
        if (!rst_n)      q <= 1'b0;
        else if (set_i)  q <= 1'b1;
        else if (clr_i)  q <= 1'b0;
    end

    assert_set_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> q);
    assert_w1c_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !q);
    assert_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && !set_i && q) |=> q);
endmodule

// File: rtl/smi_io_trap.sv
// Flags an I/O access whose address equals either of two watched ports.
// Assumes the snoop address is valid whenever valid_i is high.
module smi_io_trap #(
    parameter int              ADDR_W = 16,
    parameter logic [ADDR_W-1:0] PORT_A = 16'h0062,
    parameter logic [ADDR_W-1:0] PORT_B = 16'h0066
) (
    input  logic              valid_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              hit_o
);
    // Compare the snooped address with both watched ports.
    always_comb begin
        hit_o = valid_i && ((addr_i == PORT_A) || (addr_i == PORT_B));
    end
endmodule

// File: rtl/smi_live_terms.sv
// Builds the live summary bits from other status registers and enables.
// Assumes all inputs are already synchronous; output is combinational.
module smi_live_terms #(
    parameter int NUM_TRAPS = 8,
    parameter int GPE0_W    = 16,
    parameter int GPE1_W    = 16,
    parameter int PM1_W     = 16
) (
    input  logic [NUM_TRAPS-1:0] trap_sts,
    input  logic [NUM_TRAPS-1:0] trap_en,
    input  logic [GPE0_W-1:0]    gpe0_sts,
    input  logic [GPE0_W-1:0]    gpe0_en,
    input  logic [GPE1_W-1:0]    gpe1_sts,
    input  logic [GPE1_W-1:0]    gpe1_en,
    input  logic [GPE1_W-1:0]    gpe1_route,
    input  logic [PM1_W-1:0]     pm1_sts,
    input  logic [PM1_W-1:0]     pm1_smi_mask,
    output logic                 devtrap_o,
    output logic                 gpe0_o,
    output logic                 gpe1_o,
    output logic                 pm1_o
);
    // Reduce each qualified vector to one summary bit.
    always_comb begin
        devtrap_o = |(trap_sts & trap_en);
        gpe0_o    = |(gpe0_sts & gpe0_en);
        gpe1_o    = |(gpe1_sts & gpe1_en & gpe1_route);
        pm1_o     = |(pm1_sts & pm1_smi_mask);
    end
endmodule

// File: rtl/smi_out_drive.sv
// Registers the active-low SMI request from the qualified-cause flag.
// Assumes qual_i is the OR of all enabled causes in the current cycle.
module smi_out_drive (
    input  logic clk,
    input  logic rst_n,
    input  logic qual_i,
    output logic smi_n
);
    // Drive SMI low the cycle after any qualified cause is present.
    always_ff @(posedge clk) begin
        if (!rst_n) smi_n <= 1'b1;
        else        smi_n <= ~qual_i;
    end

    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> smi_n);
    assert_smi_raise_R10: assert property (@(posedge clk) disable iff (!rst_n)
        qual_i |=> !smi_n);
    assert_smi_release_R13: assert property (@(posedge clk) disable iff (!rst_n)
        !qual_i |=> smi_n);
endmodule

// File: rtl/smi_cause_reg.sv
// SMI status aggregation register: latched W1C causes, live level and
// summary causes, an I/O port trap, and a registered active-low SMI.
// Assumes one clock domain and a synchronous active-low reset.
module smi_cause_reg #(
    parameter int              OFS_W     = 8,
    parameter logic [OFS_W-1:0] REG_OFS  = 8'h34,
    parameter int              ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] PORT_A  = 16'h0062,
    parameter logic [ADDR_W-1:0] PORT_B  = 16'h0066,
    parameter int              NUM_TRAPS = 8,
    parameter int              GPE0_W    = 16,
    parameter int              GPE1_W    = 16,
    parameter int              PM1_W     = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [OFS_W-1:0]     reg_addr,
    input  logic                 reg_wr_en,
    input  logic [31:0]          reg_wdata,
    output logic [31:0]          reg_rdata,
    input  logic [31:0]          smi_en,
    input  logic                 io_snoop_valid,
    input  logic [ADDR_W-1:0]    io_snoop_addr,
    input  logic                 smb_slave_evt,
    input  logic                 smb_alert_n,
    input  logic                 smb_smi_mode,
    input  logic                 serirq_req,
    input  logic                 periodic_tick,
    input  logic                 tco_req,
    input  logic [NUM_TRAPS-1:0] trap_sts,
    input  logic [NUM_TRAPS-1:0] trap_en,
    input  logic [GPE0_W-1:0]    gpe0_sts,
    input  logic [GPE0_W-1:0]    gpe0_en,
    input  logic [GPE1_W-1:0]    gpe1_sts,
    input  logic [GPE1_W-1:0]    gpe1_en,
    input  logic [GPE1_W-1:0]    gpe1_route,
    input  logic [PM1_W-1:0]     pm1_sts,
    input  logic [PM1_W-1:0]     pm1_smi_mask,
    output logic                 smi_n
);
    import smi_pkg::*;

    logic                 wr_hit;
    logic                 alert_prev_n;
    logic                 alert_fall;
    logic                 trap_hit;
    logic [NUM_LATCH-1:0] latch_set;
    logic [NUM_LATCH-1:0] latch_q;
    logic                 devtrap_live, gpe0_live, gpe1_live, pm1_live;
    logic [REG_W-1:0]     status;
    logic                 qual_any;

    assign wr_hit = reg_wr_en && (reg_addr == REG_OFS);

    // Remember the alert level to find its falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n) alert_prev_n <= 1'b1;
        else        alert_prev_n <= smb_alert_n;
    end
    assign alert_fall = alert_prev_n && !smb_alert_n;

    smi_io_trap #(.ADDR_W(ADDR_W), .PORT_A(PORT_A), .PORT_B(PORT_B)) u_trap (
        .valid_i (io_snoop_valid),
        .addr_i  (io_snoop_addr),
        .hit_o   (trap_hit)
    );

    // Route each event source to its latched slot.
    always_comb begin
        latch_set[0] = smb_slave_evt || (smb_smi_mode && alert_fall);
        latch_set[1] = periodic_tick;
        latch_set[2] = trap_hit;
    end

    for (genvar s = 0; s < NUM_LATCH; s++) begin : g_latch
        smi_w1c_bit u_bit (
            .clk   (clk),
            .rst_n (rst_n),
            .set_i (latch_set[s]),
            .clr_i (wr_hit && reg_wdata[latch_pos(s)]),
            .q     (latch_q[s])
        );
    end

    smi_live_terms #(
        .NUM_TRAPS(NUM_TRAPS), .GPE0_W(GPE0_W), .GPE1_W(GPE1_W), .PM1_W(PM1_W)
    ) u_live (
        .trap_sts     (trap_sts),
        .trap_en      (trap_en),
        .gpe0_sts     (gpe0_sts),
        .gpe0_en      (gpe0_en),
        .gpe1_sts     (gpe1_sts),
        .gpe1_en      (gpe1_en),
        .gpe1_route   (gpe1_route),
        .pm1_sts      (pm1_sts),
        .pm1_smi_mask (pm1_smi_mask),
        .devtrap_o    (devtrap_live),
        .gpe0_o       (gpe0_live),
        .gpe1_o       (gpe1_live),
        .pm1_o        (pm1_live)
    );

    // Assemble the visible status word; unlisted bits stay zero.
    always_comb begin
        status             = '0;
        status[BIT_PM1]    = pm1_live;
        status[BIT_GPE0]   = gpe0_live;
        status[BIT_GPE1]   = gpe1_live;
        status[BIT_DEVTRP] = devtrap_live;
        status[BIT_TCO]    = tco_req;
        status[BIT_SERIRQ] = serirq_req;
        for (int s = 0; s < NUM_LATCH; s++) status[latch_pos(s)] = latch_q[s];
    end

    // Qualify every status bit by its enable or by its built-in enable.
    always_comb begin
        qual_any = |(status & (smi_en | NOEN_MASK));
    end

    // Return the status word only at the register's own offset.
    always_comb begin
        reg_rdata = (reg_addr == REG_OFS) ? status : '0;
    end

    smi_out_drive u_out (
        .clk    (clk),
        .rst_n  (rst_n),
        .qual_i (qual_any),
        .smi_n  (smi_n)
    );

    assert_rsvd_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata & RSVD_MASK) == '0);
    assert_port_trap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (io_snoop_valid && (io_snoop_addr == PORT_A || io_snoop_addr == PORT_B))
        |=> status[BIT_MCPORT]);
    assert_alert_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (smb_smi_mode && $fell(smb_alert_n)) |=> status[BIT_SMBUS]);
endmodule

// File: tb/test_smi_cause_reg.sv
module test_smi_cause_reg;
    localparam int NT = 4;
    localparam int GW = 8;
    localparam logic [31:0] NOEN = 32'h0000_1700;
    localparam logic [31:0] RSVD = 32'hFFFE_0080;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [7:0]  b_addr = 8'h34;
    logic        b_wr = 1'b0;
    logic [31:0] b_wdata = '0;
    logic [31:0] b_en = '0;
    logic        snp_v = 1'b0;
    logic [15:0] snp_a = '0;
    logic        slave = 1'b0, alert_n = 1'b1, smode = 1'b0;
    logic        serirq = 1'b0, tick = 1'b0, tco = 1'b0;
    logic [NT-1:0] trs = '0, tre = '0;
    logic [GW-1:0] g0s = '0, g0e = '0, g1s = '0, g1e = '0, g1r = '0, pms = '0, pmm = '0;
    logic [31:0] rdata;
    logic        smi_n;

    logic m16 = 1'b0, m14 = 1'b0, m11 = 1'b0, m_prev = 1'b1, m_smi_n = 1'b1;
    int checks = 0, fails = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    smi_cause_reg #(.NUM_TRAPS(NT), .GPE0_W(GW), .GPE1_W(GW), .PM1_W(GW)) i_smi_cause_reg (
        .clk(clk), .rst_n(rst_n), .reg_addr(b_addr), .reg_wr_en(b_wr),
        .reg_wdata(b_wdata), .reg_rdata(rdata), .smi_en(b_en),
        .io_snoop_valid(snp_v), .io_snoop_addr(snp_a),
        .smb_slave_evt(slave), .smb_alert_n(alert_n), .smb_smi_mode(smode),
        .serirq_req(serirq), .periodic_tick(tick), .tco_req(tco),
        .trap_sts(trs), .trap_en(tre), .gpe0_sts(g0s), .gpe0_en(g0e),
        .gpe1_sts(g1s), .gpe1_en(g1e), .gpe1_route(g1r),
        .pm1_sts(pms), .pm1_smi_mask(pmm), .smi_n(smi_n)
    );

    function automatic logic [31:0] exp_status();
        logic [31:0] v = '0;
        v[8]  = |(pms & pmm);
        v[9]  = |(g0s & g0e);
        v[10] = |(g1s & g1e & g1r);
        v[11] = m11;
        v[12] = |(trs & tre);
        v[13] = tco;
        v[14] = m14;
        v[15] = serirq;
        v[16] = m16;
        return v;
    endfunction

    function automatic logic [31:0] exp_read();
        return (b_addr == 8'h34) ? exp_status() : 32'h0;
    endfunction

    task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic idle();
        b_addr = 8'h34; b_wr = 0; b_wdata = '0; snp_v = 0; snp_a = '0;
        slave = 0; tick = 0; serirq = 0; tco = 0;
    endtask

    // Check the current cycle, then advance model and design by one clock.
    task automatic step(string tag);
        logic [31:0] clr;
        logic n16, n14, n11, nsmi;
        #1;
        check(tag, "rdata", rdata, exp_read());
        check(tag, "smi_n", {31'b0, smi_n}, {31'b0, m_smi_n});
        clr  = (b_wr && b_addr == 8'h34) ? b_wdata : 32'h0;
        n16  = slave || (smode && m_prev && !alert_n) || (m16 && !clr[16]);
        n14  = tick || (m14 && !clr[14]);
        n11  = (snp_v && (snp_a == 16'h62 || snp_a == 16'h66)) || (m11 && !clr[11]);
        nsmi = !(|(exp_status() & (b_en | NOEN)));
        @(posedge clk);
        if (!rst_n) begin
            m16 = 0; m14 = 0; m11 = 0; m_prev = 1; m_smi_n = 1;
        end else begin
            m16 = n16; m14 = n14; m11 = n11; m_prev = alert_n; m_smi_n = nsmi;
        end
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin : main
        void'($urandom(32'd20240611));
        @(negedge clk);
        idle();
        repeat (3) step("R1");
        rst_n = 1;
        step("R1");
        step("R1");

        // R3: slave event latches, W1C clears
        slave = 1; step("R3"); slave = 0; step("R3");
        b_wr = 1; b_wdata = 32'h0001_0000; step("R3"); idle(); step("R3");

        // R4: alert edge in SMI mode, held low sets once
        smode = 1; alert_n = 0; step("R4"); step("R4");
        b_wr = 1; b_wdata = 32'h0001_0000; step("R4"); idle();
        step("R4"); step("R4");
        alert_n = 1; smode = 0; step("R4"); alert_n = 0; step("R4"); step("R4");
        alert_n = 1; step("R4");

        // R5: live level bits
        serirq = 1; tco = 1; step("R5"); serirq = 0; step("R5"); tco = 0; step("R5");

        // R6: periodic tick and clear
        tick = 1; step("R6"); tick = 0; step("R6");
        b_wr = 1; b_wdata = 32'h0000_4000; step("R6"); idle(); step("R6");

        // R7: port trap hits and misses
        snp_v = 1; snp_a = 16'h64; step("R7"); snp_v = 0; step("R7");
        snp_v = 1; snp_a = 16'h62; step("R7"); snp_v = 0; step("R7");
        b_wr = 1; b_wdata = 32'h0000_0800; step("R7"); idle(); step("R7");
        snp_v = 1; snp_a = 16'h66; step("R7"); snp_v = 0; step("R7");

        // R8 and R9: summary bits
        trs = 4'b0101; tre = 4'b0100; step("R8"); tre = 4'b1010; step("R8");
        trs = '0; tre = '0;
        g1s = 8'h0F; g1e = 8'h08; g1r = 8'h00; step("R9"); g1r = 8'h08; step("R9");
        g1s = '0; g0s = 8'h30; g0e = 8'h10; step("R9"); g0e = '0; step("R9");
        pms = 8'h81; pmm = 8'h01; step("R9"); pms = '0; pmm = '0; step("R9");

        // R10: enable gating of latched bits
        tick = 1; step("R10"); tick = 0; step("R10"); step("R10");
        b_en = 32'h0000_4000; step("R10"); step("R10");

        // R11: set and clear in the same cycle
        tick = 1; b_wr = 1; b_wdata = 32'h0000_4000; step("R11"); idle(); step("R11");

        // R12: ignored writes
        b_addr = 8'h30; b_wr = 1; b_wdata = 32'hFFFF_FFFF; step("R12");
        b_addr = 8'h34; b_wdata = ~32'h0001_4800; step("R12");
        b_wdata = 32'h0; step("R12"); idle(); step("R12");
        b_wr = 1; b_wdata = 32'h0000_4000; step("R12"); idle(); step("R12");

        // R13: held cause keeps SMI, release restores
        trs = 4'b0010; tre = 4'b0010; repeat (4) step("R13");
        trs = '0; step("R13"); step("R13"); tre = '0;

        // Random mix
        for (int i = 0; i < 3000; i++) begin
            idle();
            b_addr  = ($urandom % 8 == 0) ? 8'h30 : 8'h34;
            b_wr    = ($urandom % 4 == 0);
            b_wdata = $urandom;
            b_en    = $urandom;
            snp_v   = ($urandom % 3 == 0);
            snp_a   = 16'h60 + 16'($urandom % 8);
            slave   = ($urandom % 10 == 0);
            alert_n = ($urandom % 3 != 0);
            smode   = $urandom;
            serirq  = ($urandom % 5 == 0);
            tick    = ($urandom % 8 == 0);
            tco     = ($urandom % 6 == 0);
            trs = NT'($urandom); tre = NT'($urandom);
            g0s = GW'($urandom); g0e = GW'($urandom % 4);
            g1s = GW'($urandom); g1e = GW'($urandom); g1r = GW'($urandom % 3);
            pms = GW'($urandom % 5); pmm = GW'($urandom);
            #1;
            check("R2", "reserved", rdata & RSVD, 32'h0);
            #1;
            step((i % 2 == 0) ? "R9" : "R10");
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule